// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block makes exceptions precise in an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. Each instruction enters from fetch with a valid bit and its PC. As it moves down the pipe, the block holds beside it a single exception flag and a cause code. Faults are seen in three stages: a bad fetch address in fetch, an illegal opcode in decode and an arithmetic overflow in execute. Each one is only recorded in the flag. Nothing happens until the instruction reaches the memory stage, which is the commit point. A data address fault found there is also considered.

An external interrupt request is not tied to any instruction. It is sampled at the commit point and overrides every instruction fault. If the memory stage holds a bubble, the request waits until a valid instruction arrives there.

When an exception commits, the block does four things in the same cycle:
- it raises kill strobes for fetch, decode, execute and writeback;
- it flushes its own stage flags;
- it asserts a redirect carrying the handler address;
- at the clock edge that ends the cycle, it loads the Cause and EPC registers.

The datapath uses a separate write-permit output to gate register-file and memory writes. That output is high only for a valid instruction that is clean at commit.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset, Cause reads 0, EPC reads 0, and the kill strobes, redirect and write-permit are all low while the pipe is empty.
- R2: A fault that an instruction picks up in fetch, decode or execute causes no kill and no redirect until that instruction occupies the memory stage, three cycles after it was presented at fetch.
- R3: When several faults apply to one instruction, the earliest stage wins. Cause codes are: fetch address fault = 4, illegal opcode = 10, overflow = 12, data address fault = 5 (the data address fault is used only when no earlier fault is carried).
- R4: An interrupt request high while a valid instruction is at the memory stage commits with cause code 0, whatever faults that instruction carries.
- R5: An interrupt request while the memory stage holds a bubble causes no action and leaves Cause and EPC unchanged. If the request is still high when a valid instruction reaches commit, it is taken there.
- R6: In the commit cycle, kill_fetch, kill_decode, kill_execute, kill_writeback and redirect_valid are all high, and redirect_pc equals the HANDLER_PC parameter. In every other cycle all five are low.
- R7: At the clock edge that ends a commit cycle, Cause takes the selected code and EPC takes the PC of the committing instruction. With no commit, both hold their values.
- R8: Instructions that are in fetch, decode or execute during a commit cycle are discarded. Faults they carry never produce a later commit.
- R9: The write-permit output is high exactly when the memory stage holds a valid instruction with no carried fault, no data address fault and no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_vld_i | input | 1 | A valid instruction is at fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the fetch-stage instruction |
| fetch_fault_i | input | 1 | Fetch address fault for the fetch-stage instruction |
| dec_illegal_i | input | 1 | Illegal opcode for the decode-stage instruction |
| exe_ovf_i | input | 1 | Arithmetic overflow for the execute-stage instruction |
| mem_dadr_fault_i | input | 1 | Data address fault for the memory-stage instruction |
| irq_i | input | 1 | External interrupt request (level) |
| kill_fetch_o | output | 1 | Discard the fetch-stage instruction |
| kill_decode_o | output | 1 | Discard the decode-stage instruction |
| kill_execute_o | output | 1 | Discard the execute-stage instruction |
| kill_wb_o | output | 1 | Block writeback of the committing instruction |
| redirect_vld_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Handler address |
| commit_ok_o | output | 1 | Memory-stage instruction may write register file and memory |
| cause_o | output | 5 | Cause register |
| epc_o | output | PC_W | Exception PC register |

## Verification
Several behaviours are checked on every cycle by assertions:
- a bubble at commit never triggers an exception;
- a commit empties every stage flag on the next cycle;
- Cause and EPC move only after a commit, and EPC then holds the committed PC;
- an interrupt always yields code 0;
- a carried fault always reaches commit with its own code;
- write-permit and commit are never high together.

Some behaviours only the bench scenarios can show. A sweep over all 32 combinations of the four fault sources and the interrupt shows the exact cycle in which each fault acts and the full priority order. Further scenarios show that an interrupt held over bubbles is deferred and then taken, and that younger faulting instructions behind a commit never surface.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int CAUSE_W   = 5;
  localparam int N_STAGES  = 3;  // decode, execute, memory holding registers

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ   = 5'd0,
    CAUSE_FETCH = 5'd4,
    CAUSE_DADR  = 5'd5,
    CAUSE_ILL   = 5'd10,
    CAUSE_OVF   = 5'd12
  } cause_e;

  // Code attached by the holding register of stage k (fault detected upstream)
  function automatic cause_e stage_code(input int k);
    case (k)
      0:       return CAUSE_FETCH;
      1:       return CAUSE_ILL;
      default: return CAUSE_OVF;
    endcase
  endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_ctrl_pkg::*;
#(
  parameter int     PC_W     = 32,
  parameter cause_e NEW_CODE = CAUSE_FETCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               in_vld,
  input  logic [PC_W-1:0]    in_pc,
  input  logic               in_exc,
  input  logic [CAUSE_W-1:0] in_code,
  input  logic               new_flag,
  output logic               q_vld,
  output logic [PC_W-1:0]    q_pc,
  output logic               q_exc,
  output logic [CAUSE_W-1:0] q_code
);
  logic               d_vld;
  logic               d_exc;
  logic [CAUSE_W-1:0] d_code;
  logic               pay_en;

  always_comb begin
    d_vld  = in_vld & ~flush;
    d_exc  = in_vld & (in_exc | new_flag) & ~flush;
    // an earlier stage's fault is kept over the one found here
    d_code = in_exc ? in_code : CAUSE_W'(NEW_CODE);
    pay_en = in_vld | q_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_exc  <= 1'b0;
      q_pc   <= '0;
      q_code <= '0;
    end else begin
      q_vld <= d_vld;
      q_exc <= d_exc;
      if (pay_en) begin
        q_pc   <= in_pc;
        q_code <= d_code;
      end
    end
  end
endmodule

// File: rtl/exc_commit_sel.sv
module exc_commit_sel
  import exc_ctrl_pkg::*;
(
  input  logic               m_vld,
  input  logic               m_exc,
  input  logic [CAUSE_W-1:0] m_code,
  input  logic               dadr_fault,
  input  logic               irq,
  output logic               take,
  output logic               clean,
  output logic [CAUSE_W-1:0] code
);
  logic any_evt;

  always_comb begin
    any_evt = m_exc | dadr_fault | irq;
    take    = m_vld & any_evt;
    clean   = m_vld & ~any_evt;
    if (irq)        code = CAUSE_W'(CAUSE_IRQ);
    else if (m_exc) code = m_code;
    else            code = CAUSE_W'(CAUSE_DADR);
  end
endmodule

// File: rtl/exc_cause_regs.sv
module exc_cause_regs
  import exc_ctrl_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CAUSE_W-1:0] code,
  input  logic [PC_W-1:0]    pc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q
);
  logic [CAUSE_W-1:0] cause_d;
  logic [PC_W-1:0]    epc_d;

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    if (take) begin
      cause_d = code;
      epc_d   = pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (take) begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
    end
  end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int            PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_vld_i,
  input  logic [PC_W-1:0]    fetch_pc_i,
  input  logic               fetch_fault_i,
  input  logic               dec_illegal_i,
  input  logic               exe_ovf_i,
  input  logic               mem_dadr_fault_i,
  input  logic               irq_i,
  output logic               kill_fetch_o,
  output logic               kill_decode_o,
  output logic               kill_execute_o,
  output logic               kill_wb_o,
  output logic               redirect_vld_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               commit_ok_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o
);
  localparam int LAST = N_STAGES - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [N_STAGES-1:0] s_vld;
  logic [N_STAGES-1:0] s_exc;
  logic [PC_W-1:0]     s_pc   [N_STAGES];
  logic [CAUSE_W-1:0]  s_code [N_STAGES];
  logic [N_STAGES-1:0] src_flag;
  logic                take;
  logic                clean;
  logic [CAUSE_W-1:0]  sel_code;

  assign src_flag = {exe_ovf_i, dec_illegal_i, fetch_fault_i};

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic               in_vld;
    logic [PC_W-1:0]    in_pc;
    logic               in_exc;
    logic [CAUSE_W-1:0] in_code;
    if (k == 0) begin : g_head
      assign in_vld  = fetch_vld_i;
      assign in_pc   = fetch_pc_i;
      assign in_exc  = 1'b0;
      assign in_code = '0;
    end else begin : g_link
      assign in_vld  = s_vld[k-1];
      assign in_pc   = s_pc[k-1];
      assign in_exc  = s_exc[k-1];
      assign in_code = s_code[k-1];
    end
    exc_stage_reg #(.PC_W(PC_W), .NEW_CODE(stage_code(k))) u_stage (
      .clk      (clk),
      .rst_n    (rst_q),
      .flush    (take),
      .in_vld   (in_vld),
      .in_pc    (in_pc),
      .in_exc   (in_exc),
      .in_code  (in_code),
      .new_flag (src_flag[k]),
      .q_vld    (s_vld[k]),
      .q_pc     (s_pc[k]),
      .q_exc    (s_exc[k]),
      .q_code   (s_code[k])
    );
  end

  exc_commit_sel u_sel (
    .m_vld      (s_vld[LAST]),
    .m_exc      (s_exc[LAST]),
    .m_code     (s_code[LAST]),
    .dadr_fault (mem_dadr_fault_i),
    .irq        (irq_i),
    .take       (take),
    .clean      (clean),
    .code       (sel_code)
  );

  exc_cause_regs #(.PC_W(PC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .take    (take),
    .code    (sel_code),
    .pc      (s_pc[LAST]),
    .cause_q (cause_o),
    .epc_q   (epc_o)
  );

  always_comb begin
    kill_fetch_o   = take;
    kill_decode_o  = take;
    kill_execute_o = take;
    kill_wb_o      = take;
    redirect_vld_o = take;
    redirect_pc_o  = HANDLER_PC;
    commit_ok_o    = clean;
  end

  // R5
  bubble_no_take_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !s_vld[LAST] |-> !take);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_q)
    take |=> (s_vld == '0) && (s_exc == '0));
  // R7
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    take |=> (epc_o == $past(s_pc[LAST])) && (cause_o == $past(sel_code)));
  // R7
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !take |=> $stable(cause_o) && $stable(epc_o));
  // R4
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (s_vld[LAST] && irq_i) |-> take && (sel_code == CAUSE_W'(CAUSE_IRQ)));
  // R3
  carried_code_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (s_vld[LAST] && s_exc[LAST] && !irq_i) |-> take && (sel_code == s_code[LAST]));
  // R9
  permit_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(commit_ok_o && take));
endmodule

// File: tb/exc_commit_ctrl_tb.sv
module exc_commit_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          PC_W       = 32;
  localparam logic [31:0] HANDLER    = 32'h0000_0180;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            fetch_vld, fetch_fault, dec_ill, exe_ovf, dadr, irq;
  logic [PC_W-1:0] fetch_pc;
  logic            k_f, k_d, k_e, k_w, rd_vld, ok;
  logic [PC_W-1:0] rd_pc, epc;
  logic [4:0]      cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [4:0]  exp_cause = 5'd0;
  logic [31:0] exp_epc   = 32'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld_i(fetch_vld), .fetch_pc_i(fetch_pc), .fetch_fault_i(fetch_fault),
    .dec_illegal_i(dec_ill), .exe_ovf_i(exe_ovf), .mem_dadr_fault_i(dadr),
    .irq_i(irq),
    .kill_fetch_o(k_f), .kill_decode_o(k_d), .kill_execute_o(k_e), .kill_wb_o(k_w),
    .redirect_vld_o(rd_vld), .redirect_pc_o(rd_pc), .commit_ok_o(ok),
    .cause_o(cause), .epc_o(epc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all kill strobes and redirect must equal the expected commit flag
  task automatic check_take(input string req, input bit exp_take);
    check(req, {27'd0, k_f, k_d, k_e, k_w, rd_vld}, exp_take ? 32'h1f : 32'h0);
    if (exp_take) check(req, rd_pc, HANDLER);
  endtask

  task automatic check_regs(input string req);
    check(req, {27'd0, cause}, {27'd0, exp_cause});
    check(req, epc, exp_epc);
  endtask

  task automatic idle_inputs();
    fetch_vld = 0; fetch_fault = 0; dec_ill = 0; exe_ovf = 0; dadr = 0; irq = 0;
    fetch_pc = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  function automatic logic [4:0] code_of(input logic [4:0] m);
    if (m[4])      return 5'd0;
    else if (m[0]) return 5'd4;
    else if (m[1]) return 5'd10;
    else if (m[2]) return 5'd12;
    else           return 5'd5;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) next_cycle();
    rst_n = 1'b1;
    repeat (4) next_cycle();
    #1;
    // R1 reset state
    check_regs("R1 reset regs");
    check_take("R1 reset strobes", 1'b0);
    check("R1 reset permit", {31'd0, ok}, 32'd0);

    // R2 R3 R4 R6 R7 R9: sweep every fault/interrupt combination
    for (int m = 0; m < 32; m++) begin
      logic [4:0]  mk;
      logic [31:0] pc;
      bit          tk;
      mk = m[4:0];
      pc = 32'h0000_1000 + 32'(m) * 4;
      tk = (mk != 5'd0);
      next_cycle();
      fetch_vld = 1; fetch_pc = pc; fetch_fault = mk[0];
      #1 check_take("R2 fetch cycle quiet", 1'b0);
      next_cycle();
      idle_inputs(); dec_ill = mk[1];
      #1 check_take("R2 decode cycle quiet", 1'b0);
      next_cycle();
      idle_inputs(); exe_ovf = mk[2];
      #1 check_take("R2 execute cycle quiet", 1'b0);
      next_cycle();
      idle_inputs(); dadr = mk[3]; irq = mk[4];
      #1;
      check_take("R6 commit strobes", tk);
      check("R9 write permit", {31'd0, ok}, {31'd0, !tk});
      next_cycle();
      idle_inputs();
      if (tk) begin
        exp_cause = code_of(mk);
        exp_epc   = pc;
      end
      #1;
      check_regs(mk[4] ? "R4 interrupt cause" : "R3 R7 cause and epc");
      check_take("R6 quiet after commit", 1'b0);
    end

    // R5: interrupt over bubbles is deferred, then taken
    next_cycle();
    idle_inputs(); irq = 1;
    for (int i = 0; i < 3; i++) begin
      #1 check_take("R5 irq on bubble ignored", 1'b0);
      check_regs("R5 regs unchanged on bubble");
      next_cycle();
    end
    fetch_vld = 1; fetch_pc = 32'h0000_2000;
    next_cycle(); fetch_vld = 0;
    #1 check_take("R5 still waiting", 1'b0);
    next_cycle();
    #1 check_take("R5 still waiting", 1'b0);
    next_cycle();
    #1 check_take("R5 deferred irq taken", 1'b1);
    check("R5 permit low", {31'd0, ok}, 32'd0);
    next_cycle(); idle_inputs();
    exp_cause = 5'd0; exp_epc = 32'h0000_2000;
    #1 check_regs("R5 deferred irq regs");

    // R8: younger faulting instructions behind a commit are discarded
    next_cycle();
    for (int i = 0; i < 4; i++) begin
      fetch_vld = 1; fetch_pc = 32'h0000_3000 + 32'(i) * 4; fetch_fault = 1;
      dec_ill = (i >= 1); exe_ovf = (i >= 2);
      #1;
      if (i == 3) check_take("R8 oldest commits", 1'b1);
      else        check_take("R8 no early action", 1'b0);
      next_cycle();
    end
    idle_inputs();
    exp_cause = 5'd4; exp_epc = 32'h0000_3000;
    for (int i = 0; i < 4; i++) begin
      #1 check_take("R8 killed instructions silent", 1'b0);
      check_regs("R8 regs keep oldest");
      next_cycle();
    end

    // R9: clean instruction gets write permit only in its commit cycle
    fetch_vld = 1; fetch_pc = 32'h0000_4000;
    #1 check("R9 permit low at fetch", {31'd0, ok}, 32'd0);
    next_cycle(); idle_inputs();
    next_cycle();
    next_cycle();
    #1 check("R9 permit at commit", {31'd0, ok}, 32'd1);
    check_take("R9 clean no strobes", 1'b0);
    next_cycle();
    #1 check_regs("R7 clean leaves regs");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule